// File: doc/BRIEF.md
# Pipeline Read-After-Write Stall Controller

This block is the hazard controller for a five-stage in-order pipeline that has no bypass paths. Each cycle it looks at three instruction words: the one sitting in decode, the one in execute and the one in memory access. It works out which register fields of the decode instruction are real reads and which register, if any, the two older instructions will write. When a real read names a register that an older instruction has still to write back, the decode instruction must wait.

The answer is given as one two-bit control code for each pipeline register: the fetch register, the decode register, the execute register and the memory register. On a hazard, fetch and decode hold their contents, execute receives an empty slot, and memory keeps flowing. With no hazard, every register takes its next value. The register file writes early in the cycle and reads late, so an instruction in write-back never causes a wait and is not an input here. The block is purely combinational: its codes follow its inputs within the same cycle.

Top module: `hzd_stall_ctl`

## Requirements
- R1: Field positions are fixed: opcode in bits [31:26], first source field in bits [25:21], second source field in bits [20:16], ALU destination in bits [4:0], ALU function code in bits [11:5], literal select in bit 12.
- R2: An instruction counts as an ALU operation only for opcode 0x10 with function 0x20 or 0x29, or opcode 0x11 with function 0x20, 0x40 or 0x4D; any other opcode or function pairing neither reads nor writes a register.
- R3: An ALU operation with bit 12 clear reads both source fields; with bit 12 set it reads only bits [25:21], and bits [20:13] (a literal) never cause a hazard.
- R4: A load (opcode 0x29) reads only bits [20:16] and writes the register in bits [25:21]; a store (opcode 0x2D) reads both source fields and writes no register.
- R5: A hazard exists when any real read of the decode instruction equals the destination of the execute instruction or of the memory instruction.
- R6: Register 31 is never a real read nor a real destination, so no match involving register 31 raises a hazard.
- R7: Codes are 2'b00 transfer, 2'b01 hold, 2'b10 bubble. On a hazard the outputs are fetch 01, decode 01, execute 10, memory 00; with no hazard all four are 00.
- R8: An all-zero instruction word (an empty slot) reads and writes nothing in any stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_instr | input | 32 | Instruction word held in the decode stage |
| ex_instr | input | 32 | Instruction word held in the execute stage |
| mem_instr | input | 32 | Instruction word held in the memory stage |
| if_ctl | output | 2 | Control code for the fetch pipeline register |
| id_ctl | output | 2 | Control code for the decode pipeline register |
| ex_ctl | output | 2 | Control code for the execute pipeline register |
| mem_ctl | output | 2 | Control code for the memory pipeline register |

## Verification
The block holds no state, so any wrong decode or compare appears on the four control codes in the same cycle as the offending instruction words, with no delay to wait for. A misread field position, a wrongly classed opcode or function, or a missing register-31 exclusion turns into either a spurious hold with a bubble or a missing one on a specific combination of instruction kinds and register numbers. The sweep therefore crosses every instruction kind in decode, with source registers taken from a small set that includes 31 and its neighbour, against every kind and destination in execute and in memory.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    // Instruction word geometry
    localparam int INSTR_W   = 32;
    localparam int REG_W     = 5;
    localparam int OP_W      = 6;
    localparam int FN_W      = 7;
    localparam int OP_LO     = INSTR_W - OP_W;
    localparam int SRCA_LO   = OP_LO - REG_W;
    localparam int SRCB_LO   = SRCA_LO - REG_W;
    localparam int DSTC_LO   = 0;
    localparam int FN_LO     = DSTC_LO + REG_W;
    localparam int LIT_BIT   = FN_LO + FN_W;

    localparam logic [REG_W-1:0] ZERO_REG = REG_W'((1 << REG_W) - 1);

    // Opcodes
    localparam logic [OP_W-1:0] OP_ARITH = 6'h10;
    localparam logic [OP_W-1:0] OP_LOGIC = 6'h11;
    localparam logic [OP_W-1:0] OP_LOAD  = 6'h29;
    localparam logic [OP_W-1:0] OP_STORE = 6'h2D;

    // Function codes
    localparam logic [FN_W-1:0] FN_ADD   = 7'h20;
    localparam logic [FN_W-1:0] FN_SUB   = 7'h29;
    localparam logic [FN_W-1:0] FN_OR    = 7'h20;
    localparam logic [FN_W-1:0] FN_XOR   = 7'h40;
    localparam logic [FN_W-1:0] FN_LESS  = 7'h4D;

    // Per pipe-register control code
    typedef enum logic [1:0] {
        PIPE_XFER   = 2'b00,
        PIPE_HOLD   = 2'b01,
        PIPE_BUBBLE = 2'b10
    } pipe_ctl_e;

    // Register usage of one instruction
    typedef struct packed {
        logic [REG_W-1:0] src_a;
        logic             a_vld;
        logic [REG_W-1:0] src_b;
        logic             b_vld;
        logic [REG_W-1:0] dst;
        logic             d_vld;
    } reg_use_t;

    // Control codes for the four pipeline registers
    typedef struct packed {
        pipe_ctl_e fetch;
        pipe_ctl_e decode;
        pipe_ctl_e execute;
        pipe_ctl_e memory;
    } pipe_ctl_t;

endpackage

// File: rtl/hzd_decode.sv
module hzd_decode
    import hzd_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output reg_use_t           use_o
);

    logic [OP_W-1:0] op;
    logic [FN_W-1:0] fn;
    logic            lit_sel;
    logic            is_alu;
    logic            is_ld;
    logic            is_st;
    reg_use_t        use_d;

    always_comb begin
        op      = instr_i[OP_LO +: OP_W];
        fn      = instr_i[FN_LO +: FN_W];
        lit_sel = instr_i[LIT_BIT];

        is_alu  = ((op == OP_ARITH) && ((fn == FN_ADD) || (fn == FN_SUB))) ||
                  ((op == OP_LOGIC) && ((fn == FN_OR) || (fn == FN_XOR) ||
                                        (fn == FN_LESS)));
        is_ld   = (op == OP_LOAD);
        is_st   = (op == OP_STORE);

        use_d.src_a = instr_i[SRCA_LO +: REG_W];
        use_d.src_b = instr_i[SRCB_LO +: REG_W];
        use_d.dst   = is_ld ? instr_i[SRCA_LO +: REG_W]
                            : instr_i[DSTC_LO +: REG_W];

        use_d.a_vld = (is_alu || is_st) && (use_d.src_a != ZERO_REG);
        use_d.b_vld = ((is_alu && !lit_sel) || is_ld || is_st) &&
                      (use_d.src_b != ZERO_REG);
        use_d.d_vld = (is_alu || is_ld) && (use_d.dst != ZERO_REG);

        // R3: literal form never reads the second field
        if (is_alu && lit_sel) begin
            a_r3_literal_no_b: assert (!use_d.b_vld)
                else $error("literal ALU form marked second source as read");
        end
        // R4: stores produce no destination
        if (is_st) begin
            a_r4_store_no_dst: assert (!use_d.d_vld)
                else $error("store marked as writing a register");
        end
        // R6: register 31 is never a real destination
        a_r6_no_zero_dst: assert (!(use_d.d_vld && (use_d.dst == ZERO_REG)))
            else $error("register 31 marked as destination");
    end

    assign use_o = use_d;

endmodule

// File: rtl/hzd_compare.sv
module hzd_compare
    import hzd_pkg::*;
#(
    parameter int NDST = 2
)(
    input  reg_use_t       reader_i,
    input  reg_use_t       writer_i [NDST],
    output logic           hit_o
);

    localparam int NSRC = 2;

    logic [NSRC*NDST-1:0] match;
    logic [REG_W-1:0]     src_reg [NSRC];
    logic                 src_vld [NSRC];

    always_comb begin
        src_reg[0] = reader_i.src_a;
        src_vld[0] = reader_i.a_vld;
        src_reg[1] = reader_i.src_b;
        src_vld[1] = reader_i.b_vld;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        for (genvar d = 0; d < NDST; d++) begin : g_dst
            assign match[s*NDST + d] = src_vld[s] && writer_i[d].d_vld &&
                                       (src_reg[s] == writer_i[d].dst);
        end
    end

    logic hit_d;

    always_comb begin
        hit_d = |match;
        // R5: a hit needs a real read and a real write
        if (hit_d) begin
            a_r5_hit_has_pair: assert ((reader_i.a_vld || reader_i.b_vld) &&
                                       (writer_i[0].d_vld || writer_i[NDST-1].d_vld))
                else $error("hazard reported with no real read or write");
        end
    end

    assign hit_o = hit_d;

endmodule

// File: rtl/hzd_ctl_map.sv
module hzd_ctl_map
    import hzd_pkg::*;
(
    input  logic      hit_i,
    output pipe_ctl_t ctl_o
);

    pipe_ctl_t ctl_d;

    always_comb begin
        ctl_d.fetch   = PIPE_XFER;
        ctl_d.decode  = PIPE_XFER;
        ctl_d.execute = PIPE_XFER;
        ctl_d.memory  = PIPE_XFER;
        if (hit_i) begin
            ctl_d.fetch   = PIPE_HOLD;
            ctl_d.decode  = PIPE_HOLD;
            ctl_d.execute = PIPE_BUBBLE;
        end

        // R7: fetch and decode hold together
        a_r7_hold_pair: assert ((ctl_d.fetch == PIPE_HOLD) ==
                                (ctl_d.decode == PIPE_HOLD))
            else $error("fetch and decode disagree on hold");
        // R7: a bubble into execute only while decode holds
        a_r7_bubble_with_hold: assert ((ctl_d.execute == PIPE_BUBBLE) ==
                                       (ctl_d.decode == PIPE_HOLD))
            else $error("execute bubble not paired with decode hold");
        // R7: the memory register always moves on
        a_r7_memory_flows: assert (ctl_d.memory == PIPE_XFER)
            else $error("memory register not transferring");
    end

    assign ctl_o = ctl_d;

endmodule

// File: rtl/hzd_stall_ctl.sv
module hzd_stall_ctl
    import hzd_pkg::*;
(
    input  logic [INSTR_W-1:0] id_instr,
    input  logic [INSTR_W-1:0] ex_instr,
    input  logic [INSTR_W-1:0] mem_instr,
    output logic [1:0]         if_ctl,
    output logic [1:0]         id_ctl,
    output logic [1:0]         ex_ctl,
    output logic [1:0]         mem_ctl
);

    localparam int NSTAGE = 3;
    localparam int NDST   = NSTAGE - 1;

    logic [INSTR_W-1:0] words [NSTAGE];
    reg_use_t           uses  [NSTAGE];
    reg_use_t           writers [NDST];
    logic               hit;
    pipe_ctl_t          ctl;

    assign words[0] = id_instr;
    assign words[1] = ex_instr;
    assign words[2] = mem_instr;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_dec
        hzd_decode u_dec (
            .instr_i (words[g]),
            .use_o   (uses[g])
        );
    end

    for (genvar w = 0; w < NDST; w++) begin : g_wr
        assign writers[w] = uses[w+1];
    end

    hzd_compare #(.NDST(NDST)) u_cmp (
        .reader_i (uses[0]),
        .writer_i (writers),
        .hit_o    (hit)
    );

    hzd_ctl_map u_map (
        .hit_i (hit),
        .ctl_o (ctl)
    );

    assign if_ctl  = ctl.fetch;
    assign id_ctl  = ctl.decode;
    assign ex_ctl  = ctl.execute;
    assign mem_ctl = ctl.memory;

endmodule

// File: tb/sim_hzd_stall_ctl.sv
`timescale 1ns/1ps
module sim_hzd_stall_ctl;

    localparam int K_RR = 0, K_RI = 1, K_LD = 2, K_ST = 3,
                   K_BADFN = 4, K_BADOP = 5, K_ZERO = 6, NKIND = 7;

    logic        clk = 1'b0;
    logic [31:0] id_instr = '0, ex_instr = '0, mem_instr = '0;
    logic [1:0]  if_ctl, id_ctl, ex_ctl, mem_ctl;
    int          n_vec = 0, n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    hzd_stall_ctl u0 (
        .id_instr  (id_instr),
        .ex_instr  (ex_instr),
        .mem_instr (mem_instr),
        .if_ctl    (if_ctl),
        .id_ctl    (id_ctl),
        .ex_ctl    (ex_ctl),
        .mem_ctl   (mem_ctl)
    );

    function automatic logic [4:0] regsel(int i);
        case (i)
            0: return 5'd1;
            1: return 5'd2;
            2: return 5'd30;
            default: return 5'd31;
        endcase
    endfunction

    // R1 field layout, R2 opcode/function pairs, R4 load/store opcodes
    function automatic logic [31:0] mk(int k, logic [4:0] a, logic [4:0] b,
                                       logic [4:0] c, int sel);
        logic [5:0] op;
        logic [6:0] fn;
        case (sel % 5)
            0: begin op = 6'h10; fn = 7'h20; end
            1: begin op = 6'h10; fn = 7'h29; end
            2: begin op = 6'h11; fn = 7'h20; end
            3: begin op = 6'h11; fn = 7'h40; end
            default: begin op = 6'h11; fn = 7'h4D; end
        endcase
        case (k)
            K_RR:    return {op, a, b, 3'b000, 1'b0, fn, c};
            K_RI:    return {op, a, b, 3'b010, 1'b1, fn, c};
            K_LD:    return {6'h29, a, b, 16'h0010};
            K_ST:    return {6'h2D, a, b, 16'h0008};
            K_BADFN: return {6'h10, a, b, 3'b000, 1'b0, 7'h40, c};
            K_BADOP: return {6'h12, a, b, 4'b0000, 7'h20, c};
            default: return 32'd0;
        endcase
    endfunction

    function automatic bit wr_vld(int k, logic [4:0] a, logic [4:0] c);
        if (k == K_RR || k == K_RI) return c != 5'd31;
        if (k == K_LD) return a != 5'd31;
        return 1'b0;
    endfunction

    function automatic logic [4:0] wr_reg(int k, logic [4:0] a, logic [4:0] c);
        return (k == K_LD) ? a : c;
    endfunction

    // R5 with R3/R4/R6 read rules
    function automatic bit hazard(int k, logic [4:0] a, logic [4:0] b,
                                  bit wv, logic [4:0] w);
        bit ra_rd, rb_rd;
        ra_rd = (k == K_RR || k == K_RI || k == K_ST) && (a != 5'd31);
        rb_rd = (k == K_RR || k == K_LD || k == K_ST) && (b != 5'd31);
        return wv && ((ra_rd && a == w) || (rb_rd && b == w));
    endfunction

    function automatic string tag_of(int k, bit hz, bit r31);
        if (hz)  return "R5";
        if (r31) return "R6";
        case (k)
            K_RR:            return "R1";
            K_RI:            return "R3";
            K_LD, K_ST:      return "R4";
            K_BADFN, K_BADOP: return "R2";
            default:         return "R8";
        endcase
    endfunction

    task automatic apply(logic [31:0] idw, logic [31:0] exw, logic [31:0] mw,
                         bit hz, string tag);
        logic [1:0] e_if, e_id, e_ex, e_mem;
        @(posedge clk);
        id_instr  = idw;
        ex_instr  = exw;
        mem_instr = mw;
        @(negedge clk);
        // R7 encoding: 00 transfer, 01 hold, 10 bubble
        e_if  = hz ? 2'b01 : 2'b00;
        e_id  = hz ? 2'b01 : 2'b00;
        e_ex  = hz ? 2'b10 : 2'b00;
        e_mem = 2'b00;
        n_vec++;
        if (if_ctl !== e_if || id_ctl !== e_id || ex_ctl !== e_ex ||
            mem_ctl !== e_mem) begin
            n_bad++;
            $display("FAIL %s R7 id=%h ex=%h mem=%h got %b %b %b %b exp %b %b %b %b",
                     tag, idw, exw, mw, if_ctl, id_ctl, ex_ctl, mem_ctl,
                     e_if, e_id, e_ex, e_mem);
        end
    endtask

    // Word for an older stage whose destination is d
    function automatic logic [31:0] older(int k, logic [4:0] d, int sel);
        case (k)
            K_RR, K_RI: return mk(k, 5'd3, 5'd3, d, sel);
            K_LD:       return mk(k, d, 5'd3, 5'd3, sel);
            default:    return mk(k, d, d, d, sel);
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int sel;
        sel = 0;
        // Idle pipe of empty slots: all transfer (R8)
        apply(32'd0, 32'd0, 32'd0, 1'b0, "R8");

        // Sweep decode kinds and sources against execute, then memory
        for (int stage = 0; stage < 2; stage++) begin
            for (int k = 0; k < NKIND; k++) begin
                for (int ia = 0; ia < 4; ia++) begin
                    for (int ib = 0; ib < 4; ib++) begin
                        for (int ek = 0; ek < NKIND; ek++) begin
                            for (int ed = 0; ed < 4; ed++) begin
                                logic [4:0] a, b, d, w;
                                logic [31:0] idw, ow;
                                bit wv, hz, r31;
                                a   = regsel(ia);
                                b   = regsel(ib);
                                d   = regsel(ed);
                                idw = mk(k, a, b, 5'd9, sel);
                                ow  = older(ek, d, sel + 1);
                                wv  = (ek == K_ZERO || ek == K_BADFN ||
                                       ek == K_BADOP) ? 1'b0
                                      : (ek == K_LD ? wr_vld(ek, d, 5'd3)
                                                    : wr_vld(ek, 5'd3, d));
                                w   = (ek == K_LD) ? wr_reg(ek, d, 5'd3)
                                                   : wr_reg(ek, 5'd3, d);
                                hz  = hazard(k, a, b, wv, w);
                                r31 = (d == 5'd31) && (a == 5'd31 || b == 5'd31);
                                if (stage == 0)
                                    apply(idw, ow, 32'd0, hz, tag_of(k, hz, r31));
                                else
                                    apply(idw, 32'd0, ow, hz, tag_of(k, hz, r31));
                                sel++;
                            end
                        end
                    end
                end
            end
        end

        // Both older stages busy: execute writes source a, memory loads source b
        for (int k = 0; k < NKIND; k++) begin
            for (int ia = 0; ia < 4; ia++) begin
                for (int ib = 0; ib < 4; ib++) begin
                    logic [4:0] a, b;
                    bit hz;
                    a  = regsel(ia);
                    b  = regsel(ib);
                    hz = hazard(k, a, b, a != 5'd31, a) ||
                         hazard(k, a, b, b != 5'd31, b);
                    apply(mk(k, a, b, 5'd9, ia), mk(K_RR, 5'd3, 5'd3, a, ib),
                          mk(K_LD, b, 5'd3, 5'd3, 0), hz, tag_of(k, hz, 1'b0));
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule